// File: doc/BRIEF.md
# Fully Associative Tag-Match Cache

This block is a read-side cache in which any 8-byte memory block may occupy any of 256 slots. There is no index field. A read strobe latches the 13-bit block tag and the 3-bit byte offset of a 16-bit byte address into an argument register. Every stored tag is then compared with that register at the same time. Each slot raises its own match bit, gated by the slot's valid bit. The match vector is encoded to a slot number in the same cycle, and that number selects a stored line. The byte offset then picks one byte of the line.

Lines are loaded through a fill port. The victim slot is chosen in this order:
- While any slot is still empty, the lowest-numbered empty slot is used.
- Once all slots are full, a circular FIFO pointer picks the slot. The pointer steps on every fill.

Two slots holding the same tag is an error condition. The block resolves it by taking the lower slot, and it raises a flag that stays set until reset.

Top module: `fa_cache`

## Requirements
- R1: After reset, `rsp_valid`, `rd_hit`, `rd_slot`, `rd_data` and `multi_hit` are 0, and every slot is empty, so a lookup of any address misses.
- R2: A lookup address is split into tag = `rd_addr[15:3]` and byte offset = `rd_addr[2:0]`. The tag alone decides the hit.
- R3: `rsp_valid` is high in exactly the cycle after each cycle in which `rd_en` is sampled high, and low otherwise.
- R4: `rd_hit` is high only with `rsp_valid`, and only when a valid slot holds the looked-up tag. On a miss, `rd_data` and `rd_slot` are 0.
- R5: On a hit, `rd_data` is byte k of the stored line, where k is the byte offset. Byte k is `fill_line[8k+7:8k]`.
- R6: While any slot is empty, a fill writes `fill_tag` and `fill_line` into the lowest-numbered empty slot, and that slot becomes valid.
- R7: The FIFO pointer starts at 0 and steps by one (mod 256) on every fill. Once all slots are valid, a fill replaces the slot the pointer names. So after 256 fills from reset, the next fills replace slots 0, 1, 2 and so on in turn.
- R8: If several valid slots match, the lowest-numbered one supplies `rd_slot` and `rd_data`, and `multi_hit` goes high one cycle later. It then stays high until reset.
- R9: A fill sampled at the same edge as a read strobe is visible to that lookup.
- R10: On a hit, `rd_slot` is the 8-bit number of the matching slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, latches the address |
| rd_addr | input | 16 | Byte address of the read |
| fill_en | input | 1 | Load one line into the victim slot |
| fill_tag | input | 13 | Tag of the line being loaded |
| fill_line | input | 64 | Line contents, byte k in bits 8k+7:8k |
| rsp_valid | output | 1 | Lookup result present this cycle |
| rd_hit | output | 1 | Lookup found a valid matching slot |
| rd_data | output | 8 | Selected byte, 0 on miss |
| rd_slot | output | 8 | Number of the matching slot, 0 on miss |
| multi_hit | output | 1 | Sticky flag: more than one slot matched |

## Verification
The assertions assume that `rd_en` and `fill_en` are clean levels sampled on the rising edge. They also assume that duplicate tags can enter the array only through the fill port, which is the only way the multi-hit path can be reached. The stimulus changes every input on the falling edge and holds each strobe for exactly one cycle. It inserts a duplicate tag only once, deliberately, after every slot has been filled, so that the FIFO eviction checks are not disturbed by the error case.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int BYTE_W = 8;

  // where the next fill is sent
  typedef enum logic {
    VIC_FREE = 1'b0,
    VIC_FIFO = 1'b1
  } vic_src_e;
endpackage

// File: rtl/fa_prio_enc.sv
module fa_prio_enc #(
  parameter int N  = 256,
  parameter int IW = 8
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic          multi
);
  // lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any   = |req;
  assign multi = |(req & (req - N'(1)));
endmodule

// File: rtl/fa_tag_cam.sv
module fa_tag_cam #(
  parameter int SLOTS  = 256,
  parameter int TAG_W  = 13,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [TAG_W-1:0]  arg_tag,
  output logic [SLOTS-1:0]  valid,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic              multi
);
  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [SLOTS-1:0] valid_q, valid_d;
  logic [SLOTS-1:0] match;

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_slot] <= wr_tag;
  end

  // one comparator per slot, qualified by valid
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == arg_tag);
  end

  fa_prio_enc #(.N(SLOTS), .IW(SLOT_W)) u_enc (
    .req   (match),
    .any   (hit),
    .idx   (hit_slot),
    .multi (multi)
  );

  assign valid = valid_q;

  // R10
  slot_holds_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (valid_q[hit_slot] && (tag_q[hit_slot] == arg_tag)));
endmodule

// File: rtl/fa_victim.sv
module fa_victim
  import fa_pkg::*;
#(
  parameter int SLOTS  = 256,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [SLOTS-1:0]  valid,
  output logic [SLOT_W-1:0] victim
);
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [SLOT_W-1:0] free_idx;
  logic              any_free;
  logic              unused_multi;
  vic_src_e          src;

  fa_prio_enc #(.N(SLOTS), .IW(SLOT_W)) u_free (
    .req   (~valid),
    .any   (any_free),
    .idx   (free_idx),
    .multi (unused_multi)
  );

  always_comb begin
    src    = any_free ? VIC_FREE : VIC_FIFO;
    victim = (src == VIC_FREE) ? free_idx : ptr_q;
    ptr_d  = ptr_q;
    if (fill_en) ptr_d = ptr_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (ptr_q == SLOT_W'($past(ptr_q) + SLOT_W'(1))));
  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> $stable(ptr_q));
  // R6
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid[$past(victim)]);
endmodule

// File: rtl/fa_line_store.sv
module fa_line_store #(
  parameter int SLOTS  = 256,
  parameter int SLOT_W = 8,
  parameter int OFF_W  = 3,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [7:0]        rd_byte
);
  localparam int NBYTES = 1 << OFF_W;

  logic [LINE_W-1:0] line_q [SLOTS];
  logic [LINE_W-1:0] sel_line;
  logic [7:0]        lane [NBYTES];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_slot] <= wr_line;
  end

  assign sel_line = line_q[rd_slot];

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane[b] = sel_line[8*b +: 8];
  end

  assign rd_byte = lane[rd_off];
endmodule

// File: rtl/fa_cache.sv
module fa_cache #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3,
  parameter int SLOTS  = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic                         fill_en,
  input  logic [ADDR_W-OFF_W-1:0]      fill_tag,
  input  logic [(8<<OFF_W)-1:0]        fill_line,
  output logic                         rsp_valid,
  output logic                         rd_hit,
  output logic [7:0]                   rd_data,
  output logic [$clog2(SLOTS)-1:0]     rd_slot,
  output logic                         multi_hit
);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LINE_W = 8 << OFF_W;

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  // argument register
  logic [TAG_W-1:0] arg_tag_q, arg_tag_d;
  logic [OFF_W-1:0] arg_off_q, arg_off_d;
  logic             pend_q;
  logic             multi_q, multi_d;

  logic [SLOTS-1:0]  valid;
  logic              cam_hit, cam_multi;
  logic [SLOT_W-1:0] cam_slot, victim;
  logic [7:0]        line_byte;

  always_comb begin
    arg_tag_d = arg_tag_q;
    arg_off_d = arg_off_q;
    if (rd_en) begin
      arg_tag_d = rd_addr[ADDR_W-1:OFF_W];
      arg_off_d = rd_addr[OFF_W-1:0];
    end
    multi_d = multi_q | (pend_q & cam_multi);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      arg_tag_q <= '0;
      arg_off_q <= '0;
      pend_q    <= 1'b0;
      multi_q   <= 1'b0;
    end else begin
      arg_tag_q <= arg_tag_d;
      arg_off_q <= arg_off_d;
      pend_q    <= rd_en;
      multi_q   <= multi_d;
    end
  end

  fa_tag_cam #(.SLOTS(SLOTS), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_cam (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (fill_en),
    .wr_slot  (victim),
    .wr_tag   (fill_tag),
    .arg_tag  (arg_tag_q),
    .valid    (valid),
    .hit      (cam_hit),
    .hit_slot (cam_slot),
    .multi    (cam_multi)
  );

  fa_victim #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_vic (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fill_en (fill_en),
    .valid   (valid),
    .victim  (victim)
  );

  fa_line_store #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .OFF_W(OFF_W),
                  .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_slot (victim),
    .wr_line (fill_line),
    .rd_slot (cam_slot),
    .rd_off  (arg_off_q),
    .rd_byte (line_byte)
  );

  assign rsp_valid = pend_q;
  assign rd_hit    = pend_q & cam_hit;
  assign rd_slot   = rd_hit ? cam_slot  : '0;
  assign rd_data   = rd_hit ? line_byte : '0;
  assign multi_hit = multi_q;

  // R3
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |=> rsp_valid);
  // R3
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> !rsp_valid);
  // R4
  hit_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_hit |-> rsp_valid);
  // R8
  multi_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    multi_hit |=> multi_hit);
endmodule

// File: tb/sim_fa_cache.sv
module sim_fa_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        fill_en = 1'b0;
  logic [12:0] fill_tag = '0;
  logic [63:0] fill_line = '0;
  logic        rsp_valid, rd_hit, multi_hit;
  logic [7:0]  rd_data, rd_slot;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  fa_cache u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_line(fill_line),
    .rsp_valid(rsp_valid), .rd_hit(rd_hit), .rd_data(rd_data),
    .rd_slot(rd_slot), .multi_hit(multi_hit)
  );

  // {addr, expect hit, expect slot}
  localparam logic [24:0] VEC [8] = '{
    {16'h0080, 1'b1, 8'd0},
    {16'hFFFF, 1'b1, 8'd1},
    {16'h0003, 1'b1, 8'd2},
    {16'h55E5, 1'b1, 8'd3},
    {16'h0088, 1'b0, 8'd0},
    {16'hFFF7, 1'b0, 8'd0},
    {16'h55E0, 1'b1, 8'd3},
    {16'h0086, 1'b1, 8'd0}
  };

  function automatic logic [63:0] line_of(input logic [12:0] t);
    logic [63:0] l;
    for (int k = 0; k < 8; k++)
      l[8*k +: 8] = (t[7:0] + 8'(k * 29)) ^ {3'b000, t[12:8]};
    return l;
  endfunction

  function automatic logic [7:0] byte_of(input logic [63:0] l, input logic [2:0] o);
    return l[8*o +: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [12:0] t, input logic [63:0] l);
    fill_en = 1'b1; fill_tag = t; fill_line = l;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // strobe, then sit in the response cycle
  task automatic lookup(input logic [15:0] a);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 multi_hit", 32'(multi_hit), 0);
    check("R1 rd_hit", 32'(rd_hit), 0);
    lookup(16'h0000);
    check("R1 empty miss", 32'(rd_hit), 0);
    check("R1 rd_data", 32'(rd_data), 0);

    // R6 fills go to lowest empty slot
    fill(13'h0010, line_of(13'h0010));
    fill(13'h1FFF, line_of(13'h1FFF));
    fill(13'h0000, line_of(13'h0000));
    fill(13'h0ABC, line_of(13'h0ABC));

    // R2 R4 R5 R10 table walk
    foreach (VEC[i]) begin
      logic [15:0] a;
      a = VEC[i][24:9];
      lookup(a);
      check("R3 rsp_valid", 32'(rsp_valid), 1);
      check("R4 hit", 32'(rd_hit), 32'(VEC[i][8]));
      check("R10 slot", 32'(rd_slot), 32'(VEC[i][7:0]));
      check("R5 data", 32'(rd_data),
            VEC[i][8] ? 32'(byte_of(line_of(a[15:3]), a[2:0])) : 0);
    end
    check("R3 pulse ends", 32'(rsp_valid), 1);
    @(negedge clk);
    check("R3 no strobe", 32'(rsp_valid), 0);
    check("R4 no rsp no hit", 32'(rd_hit), 0);

    // R9 fill and strobe at the same edge
    fill_en = 1'b1; fill_tag = 13'h0777; fill_line = line_of(13'h0777);
    rd_en = 1'b1; rd_addr = {13'h0777, 3'd2};
    @(negedge clk);
    fill_en = 1'b0; rd_en = 1'b0;
    check("R9 same edge hit", 32'(rd_hit), 1);
    check("R9 slot", 32'(rd_slot), 4);
    check("R9 data", 32'(rd_data), 32'(byte_of(line_of(13'h0777), 3'd2)));

    // fill slots 5..255
    for (int s = 5; s < 256; s++) fill(13'h1000 + 13'(s), line_of(13'h1000 + 13'(s)));
    lookup({13'h10FF, 3'd1});
    check("R6 last slot", 32'(rd_slot), 255);
    check("R8 no multi yet", 32'(multi_hit), 0);

    // R7 FIFO replacement once full
    fill(13'h1E00, line_of(13'h1E00));
    lookup({13'h0010, 3'd0});
    check("R7 evicted miss", 32'(rd_hit), 0);
    lookup({13'h1E00, 3'd7});
    check("R7 replaced slot0", 32'(rd_slot), 0);
    check("R7 data", 32'(rd_data), 32'(byte_of(line_of(13'h1E00), 3'd7)));
    fill(13'h1E01, line_of(13'h1E01));
    lookup({13'h1FFF, 3'd0});
    check("R7 slot1 evicted", 32'(rd_hit), 0);
    lookup({13'h1E01, 3'd0});
    check("R7 replaced slot1", 32'(rd_slot), 1);

    // R8 duplicate tag: goes to slot 2, slot 10 also holds it
    fill(13'h100A, ~line_of(13'h100A));
    lookup({13'h100A, 3'd4});
    check("R8 lowest slot", 32'(rd_slot), 2);
    check("R8 lowest data", 32'(rd_data), 32'(byte_of(~line_of(13'h100A), 3'd4)));
    check("R8 flag not yet", 32'(multi_hit), 0);
    @(negedge clk);
    check("R8 flag set", 32'(multi_hit), 1);
    lookup({13'h1E00, 3'd0});
    @(negedge clk);
    check("R8 flag sticky", 32'(multi_hit), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule